// File: doc/BRIEF.md
# Floating-Point Exception Resolver

This block closes a single-precision floating-point pipeline. For each finished operation it takes four inputs: the two source operands, the rounded value from the arithmetic datapath, the datapath's raw overflow and rounding indicators, and the exception-enable bits of the floating-point status word. From these it decides which exceptions the operation raises. It also decides whether the destination register is written, and with what value.

Three divide-by-zero cases are told apart by classifying the operands first. A finite nonzero value divided by zero, including a denormal, is a divide-by-zero. Zero divided by zero is an invalid operation. Infinity divided by zero is exact. A masked overflow is replaced by a signed infinity and also counts as inexact. Any raised exception whose enable bit is set blocks the write and requests a trap with a cause code. Every raised exception, masked or not, is accumulated in sticky flags. All outputs are registered and appear in the cycle after the operation is presented.

Top module: `fpx_resolver`

## Requirements
- R1: After reset, `wr_en` and `trap_req` are low and `exc_flags` is zero.
- R2: A divide whose divisor is ±0 and whose dividend is finite and nonzero (denormals included) raises divide-by-zero. When that exception is masked, the written value is infinity (0x7F800000) with the sign set to dividend sign XOR divisor sign.
- R3: When a raised exception's enable bit is set, the destination is not written (`wr_en` low) and `trap_req` is high. Enable bits in `fpsr`: invalid = bit 20, divide-by-zero = bit 19, overflow = bit 18, inexact = bit 17.
- R4: Zero divided by zero raises invalid, not divide-by-zero. When invalid is masked, the written value is the quiet NaN 0x7FC00000.
- R5: Infinity divided by zero raises no exception, even with every enable set. It writes infinity with the XOR sign.
- R6: When the datapath reports rounding, inexact is raised. When inexact is masked, `dp_result` is written unchanged.
- R7: An overflow raises overflow. If overflow is masked, inexact is also raised and the written value is infinity carrying `dp_result`'s sign. If overflow is enabled, inexact is raised only when rounding is reported.
- R8: A signalling NaN operand (exponent all ones, mantissa nonzero, mantissa MSB 0) raises invalid. A quiet NaN operand raises nothing and writes 0x7FC00000. NaN checks take precedence over the divide-by-zero cases. Divide special cases ignore the datapath's overflow and rounding indicators.
- R9: `exc_flags` = {invalid, divzero, overflow, inexact} (bit 3 down to bit 0). A bit is set by every raised exception, whatever its enable, and is cleared only by reset.
- R10: `trap_cause` names the highest-priority raised and enabled exception: invalid=0, divide-by-zero=1, overflow=2, inexact=3, with invalid highest and inexact lowest. Each accepted operation produces exactly one of a write or a trap.
- R11: In a cycle after `op_valid` was low, `wr_en` and `trap_req` are low and `exc_flags` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_is_div | input | 1 | The operation is a divide |
| opa | input | 32 | First operand (dividend) |
| opb | input | 32 | Second operand (divisor) |
| dp_result | input | 32 | Rounded datapath result |
| dp_overflow | input | 1 | Datapath overflow indicator |
| dp_rounded | input | 1 | Datapath rounding-occurred indicator |
| fpsr | input | 32 | Floating-point status word carrying the enables |
| wr_en | output | 1 | Destination write strobe |
| wr_data | output | 32 | Destination write value |
| trap_req | output | 1 | Trap request, one per trapping operation |
| trap_cause | output | 2 | Cause code of the trap |
| exc_flags | output | 4 | Sticky exception flags |

## Verification
The bench covers the three zero-divisor dividends, including a denormal dividend and a negative-zero divisor. A design that only tests the divisor would report divide-by-zero for 0/0 or ∞/0, or would get the infinity's sign wrong. It drives an enabled overflow after a fresh reset, with rounding on and off, to catch a design that raises inexact from every overflow rather than only from masked ones. It stacks several enabled exceptions on one operation, so a reversed priority encoder shows up as a wrong cause code. It places NaN operands on a zero divisor, so a design that checks NaNs after the divide cases raises divide-by-zero where invalid or silence is due.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int FP_W  = 1 + EXP_W + MAN_W;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    typedef struct packed {
        logic inv;
        logic dz;
        logic ovf;
        logic inx;
    } exc_t;

    typedef enum logic [1:0] {
        CAUSE_INV = 2'd0,
        CAUSE_DZ  = 2'd1,
        CAUSE_OVF = 2'd2,
        CAUSE_INX = 2'd3
    } cause_e;

    localparam logic [FP_W-1:0] QNAN_VAL = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    function automatic logic [FP_W-1:0] signed_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    endfunction
endpackage

// File: rtl/fpx_classify.sv
`timescale 1ns/1ps
module fpx_classify
    import fpx_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fp_class_t       cls
);
    logic exp_ones, exp_zero, man_zero;

    always_comb begin
        exp_ones    = &val[FP_W-2 -: EXP_W];
        exp_zero    = ~|val[FP_W-2 -: EXP_W];
        man_zero    = ~|val[MAN_W-1:0];
        cls.sign    = val[FP_W-1];
        cls.is_zero = exp_zero & man_zero;
        cls.is_inf  = exp_ones & man_zero;
        cls.is_nan  = exp_ones & ~man_zero;
        cls.is_snan = exp_ones & ~man_zero & ~val[MAN_W-1];
    end
endmodule

// File: rtl/fpx_decide.sv
`timescale 1ns/1ps
module fpx_decide
    import fpx_pkg::*;
(
    input  fp_class_t       a_cls,
    input  fp_class_t       b_cls,
    input  logic            op_is_div,
    input  logic [FP_W-1:0] dp_result,
    input  logic            dp_overflow,
    input  logic            dp_rounded,
    input  exc_t            en,
    output exc_t            raised,
    output logic [FP_W-1:0] res_val
);
    logic xor_sign;
    logic unused_cls_bits;

    assign unused_cls_bits = b_cls.is_inf;

    always_comb begin
        xor_sign = a_cls.sign ^ b_cls.sign;
        raised   = '0;
        res_val  = dp_result;
        if (a_cls.is_snan || b_cls.is_snan) begin
            raised.inv = 1'b1;
            res_val    = QNAN_VAL;
        end else if (a_cls.is_nan || b_cls.is_nan) begin
            res_val    = QNAN_VAL;
        end else if (op_is_div && b_cls.is_zero) begin
            if (a_cls.is_zero) begin
                raised.inv = 1'b1;
                res_val    = QNAN_VAL;
            end else if (a_cls.is_inf) begin
                res_val    = signed_inf(xor_sign);
            end else begin
                raised.dz  = 1'b1;
                res_val    = signed_inf(xor_sign);
            end
        end else begin
            raised.ovf = dp_overflow;
            raised.inx = dp_rounded | (dp_overflow & ~en.ovf);
            if (dp_overflow && !en.ovf) begin
                res_val = signed_inf(dp_result[FP_W-1]);
            end
        end
    end
endmodule

// File: rtl/fpx_trap_pick.sv
`timescale 1ns/1ps
module fpx_trap_pick
    import fpx_pkg::*;
(
    input  exc_t   raised,
    input  exc_t   en,
    output logic   trap,
    output cause_e cause
);
    exc_t hit;

    always_comb begin
        hit   = raised & en;
        trap  = |hit;
        cause = CAUSE_INX;
        if (hit.ovf) cause = CAUSE_OVF;
        if (hit.dz)  cause = CAUSE_DZ;
        if (hit.inv) cause = CAUSE_INV;
    end
endmodule

// File: rtl/fpx_resolver.sv
`timescale 1ns/1ps
module fpx_resolver
    import fpx_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int IV_BIT = 20,
    parameter int DZ_BIT = 19,
    parameter int OV_BIT = 18,
    parameter int NX_BIT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_is_div,
    input  logic [FP_W-1:0]   opa,
    input  logic [FP_W-1:0]   opb,
    input  logic [FP_W-1:0]   dp_result,
    input  logic              dp_overflow,
    input  logic              dp_rounded,
    input  logic [CTRL_W-1:0] fpsr,
    output logic              wr_en,
    output logic [FP_W-1:0]   wr_data,
    output logic              trap_req,
    output logic [1:0]        trap_cause,
    output logic [3:0]        exc_flags
);
    localparam int N_OPS = 2;

    typedef struct packed {
        logic            wr_en;
        logic [FP_W-1:0] wr_data;
        logic            trap;
        cause_e          cause;
        exc_t            flags;
    } state_t;

    state_t          st_d, st_q;
    exc_t            en;
    exc_t            raised;
    logic [FP_W-1:0] res_val;
    logic            pick_trap;
    cause_e          pick_cause;
    logic [FP_W-1:0] ops [N_OPS];
    fp_class_t       cls [N_OPS];
    logic            unused_ctrl_bits;

    assign unused_ctrl_bits = ^fpsr;
    assign ops[0] = opa;
    assign ops[1] = opb;

    always_comb begin
        en.inv = fpsr[IV_BIT];
        en.dz  = fpsr[DZ_BIT];
        en.ovf = fpsr[OV_BIT];
        en.inx = fpsr[NX_BIT];
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fpx_classify u_cls (
            .val (ops[g]),
            .cls (cls[g])
        );
    end

    fpx_decide u_decide (
        .a_cls       (cls[0]),
        .b_cls       (cls[1]),
        .op_is_div   (op_is_div),
        .dp_result   (dp_result),
        .dp_overflow (dp_overflow),
        .dp_rounded  (dp_rounded),
        .en          (en),
        .raised      (raised),
        .res_val     (res_val)
    );

    fpx_trap_pick u_pick (
        .raised (raised),
        .en     (en),
        .trap   (pick_trap),
        .cause  (pick_cause)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.trap  = 1'b0;
        if (op_valid) begin
            st_d.flags = st_q.flags | raised;
            st_d.trap  = pick_trap;
            st_d.wr_en = ~pick_trap;
            if (pick_trap) begin
                st_d.cause = pick_cause;
            end else begin
                st_d.wr_data = res_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{wr_en: 1'b0, wr_data: '0, trap: 1'b0, cause: CAUSE_INV, flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en      = st_q.wr_en;
    assign wr_data    = st_q.wr_data;
    assign trap_req   = st_q.trap;
    assign trap_cause = st_q.cause;
    assign exc_flags  = st_q.flags;
endmodule

// File: rtl/fpx_resolver_chk.sv
`timescale 1ns/1ps
module fpx_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic       wr_en,
    input logic       trap_req,
    input logic [1:0] trap_cause,
    input logic [3:0] exc_flags
);
    p_trap_blocks_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !wr_en);

    p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_flags & $past(exc_flags)) == $past(exc_flags));

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid) |-> (wr_en ^ trap_req));

    p_cause_flagged_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> exc_flags[2'd3 - trap_cause]);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> (!wr_en && !trap_req && $stable(exc_flags)));
endmodule

bind fpx_resolver fpx_resolver_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .wr_en      (wr_en),
    .trap_req   (trap_req),
    .trap_cause (trap_cause),
    .exc_flags  (exc_flags)
);

// File: tb/fpx_resolver_test.sv
`timescale 1ns/1ps
module fpx_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_is_div = 1'b0;
    logic [31:0] opa = '0, opb = '0, dp_result = '0, fpsr = '0;
    logic        dp_overflow = 1'b0, dp_rounded = 1'b0;
    logic        wr_en, trap_req;
    logic [31:0] wr_data;
    logic [1:0]  trap_cause;
    logic [3:0]  exc_flags;

    int checks = 0;
    int errors = 0;

    logic        e_wr = 1'b0, e_trap = 1'b0;
    logic [31:0] e_data = '0;
    logic [1:0]  e_cause = '0;
    logic [3:0]  e_flags = '0;
    string       e_tag = "R1";

    localparam logic [31:0] EN_IV = 32'h1 << 20;
    localparam logic [31:0] EN_DZ = 32'h1 << 19;
    localparam logic [31:0] EN_OV = 32'h1 << 18;
    localparam logic [31:0] EN_NX = 32'h1 << 17;
    localparam logic [31:0] QNAN  = 32'h7FC0_0000;
    localparam logic [31:0] PINF  = 32'h7F80_0000;
    localparam logic [31:0] NINF  = 32'hFF80_0000;

    fpx_resolver uut (.*);

    always #5 clk = ~clk;

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic compare();
        checks++;
        if (wr_en !== e_wr || trap_req !== e_trap || exc_flags !== e_flags ||
            (e_wr && wr_data !== e_data) || (e_trap && trap_cause !== e_cause)) begin
            errors++;
            $display("FAIL %s: actual wr=%b data=%h trap=%b cause=%0d flags=%b expected wr=%b data=%h trap=%b cause=%0d flags=%b",
                     e_tag, wr_en, wr_data, trap_req, trap_cause, exc_flags,
                     e_wr, e_data, e_trap, e_cause, e_flags);
        end
    endtask

    function automatic bit is_nan(logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction

    task automatic model(bit v, bit dv, logic [31:0] a, logic [31:0] b, logic [31:0] r,
                         bit ov, bit rn, logic [31:0] ctl);
        bit iv = 0, dz = 0, of = 0, nx = 0;
        logic [31:0] res = r;
        bit en_iv = ctl[20], en_dz = ctl[19], en_of = ctl[18], en_nx = ctl[17];
        bit a_zero = (a[30:0] == 0), b_zero = (b[30:0] == 0);
        bit a_inf = (a[30:0] == 31'h7F80_0000);
        bit a_snan = is_nan(a) && !a[22], b_snan = is_nan(b) && !b[22];
        e_wr = 0;
        e_trap = 0;
        if (!v) return;
        if (a_snan || b_snan) begin iv = 1; res = QNAN; end
        else if (is_nan(a) || is_nan(b)) res = QNAN;
        else if (dv && b_zero) begin
            if (a_zero) begin iv = 1; res = QNAN; end
            else begin
                dz = !a_inf;
                res = (a[31] ^ b[31]) ? NINF : PINF;
            end
        end else begin
            of = ov;
            nx = rn || (ov && !en_of);
            if (ov && !en_of) res = r[31] ? NINF : PINF;
        end
        e_flags = e_flags | {iv, dz, of, nx};
        if (nx && en_nx) begin e_trap = 1; e_cause = 3; end
        if (of && en_of) begin e_trap = 1; e_cause = 2; end
        if (dz && en_dz) begin e_trap = 1; e_cause = 1; end
        if (iv && en_iv) begin e_trap = 1; e_cause = 0; end
        e_wr = !e_trap;
        if (e_wr) e_data = res;
    endtask

    task automatic step(bit v, bit dv, logic [31:0] a, logic [31:0] b, logic [31:0] r,
                        bit ov, bit rn, logic [31:0] ctl, string tag);
        @(negedge clk);
        compare();
        op_valid = v; op_is_div = dv; opa = a; opb = b; dp_result = r;
        dp_overflow = ov; dp_rounded = rn; fpsr = ctl;
        model(v, dv, a, b, r, ov, rn, ctl);
        e_tag = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; op_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        e_wr = 0; e_trap = 0; e_flags = 0; e_tag = "R1";
        compare();
    endtask

    initial begin
        do_reset();
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R2: finite nonzero over zero, masked
        step(1, 1, 32'h4040_0000, 32'h0000_0000, 32'h1234_5678, 0, 0, 0, "R2");
        step(1, 1, 32'hC040_0000, 32'h0000_0000, 0, 0, 0, 0, "R2");
        step(1, 1, 32'h4040_0000, 32'h8000_0000, 0, 1, 1, 0, "R2");
        step(1, 1, 32'h0000_0001, 32'h8000_0000, 0, 0, 0, 0, "R2");
        // R3: enabled divide-by-zero traps, back to back
        step(1, 1, 32'h3F80_0000, 32'h0000_0000, 0, 0, 0, EN_DZ, "R3");
        step(1, 1, 32'hBF80_0000, 32'h0000_0000, 0, 0, 0, EN_DZ | EN_NX, "R3");
        step(0, 1, 32'hBF80_0000, 32'h0000_0000, 0, 0, 0, EN_DZ, "R11");
        // R4: zero over zero
        do_reset();
        step(1, 1, 32'h0000_0000, 32'h8000_0000, 0, 0, 0, EN_DZ, "R4");
        step(1, 1, 32'h8000_0000, 32'h0000_0000, 0, 0, 0, EN_IV, "R4");
        // R5: infinity over zero, every enable set
        do_reset();
        step(1, 1, 32'h7F80_0000, 32'h8000_0000, 0, 1, 1, 32'hFFFF_FFFF, "R5");
        step(1, 1, 32'hFF80_0000, 32'h8000_0000, 0, 0, 0, 32'hFFFF_FFFF, "R5");
        // R6: rounding
        step(1, 0, 32'h3F80_0000, 32'h4000_0000, 32'h3F8C_CCCD, 0, 1, 0, "R6");
        step(1, 0, 32'h3F80_0000, 32'h4000_0000, 32'h3EAA_AAAB, 0, 1, EN_NX, "R6");
        step(1, 0, 32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 0, 0, EN_NX, "R6");
        // R7: enabled overflow after reset, no inexact without rounding
        do_reset();
        step(1, 0, 32'h7F00_0000, 32'h7F00_0000, 32'h7F7F_FFFF, 1, 0, EN_OV, "R7");
        step(1, 0, 32'h7F00_0000, 32'h7F00_0000, 32'h7F7F_FFFF, 1, 0, 0, "R7");
        step(1, 0, 32'hFF00_0000, 32'h7F00_0000, 32'hFF7F_FFFF, 1, 0, EN_NX, "R7");
        // R10: priority overflow over inexact
        step(1, 0, 32'h7F00_0000, 32'h7F00_0000, 32'h7F7F_FFFF, 1, 1, EN_OV | EN_NX, "R10");
        // R8: NaN operands
        do_reset();
        step(1, 0, 32'h7FC0_0001, 32'h3F80_0000, 32'h7FC0_0001, 1, 1, 32'hFFFF_FFFF, "R8");
        step(1, 1, 32'h7FC0_0001, 32'h0000_0000, 0, 0, 0, EN_DZ, "R8");
        step(1, 1, 32'h7FA0_0000, 32'h0000_0000, 0, 0, 0, EN_DZ, "R8");
        step(1, 0, 32'h3F80_0000, 32'hFF80_0001, 0, 0, 0, 0, "R8");
        // R10: invalid outranks others
        step(1, 1, 32'h7F80_0001, 32'h0000_0000, 0, 1, 1, 32'hFFFF_FFFF, "R10");
        step(1, 1, 32'h4000_0000, 32'h0000_0000, 0, 1, 1, EN_DZ | EN_OV | EN_NX, "R10");
        // R9: flags sticky through idle and clean ops
        step(1, 0, 32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, 0, 0, 32'hFFFF_FFFF, "R9");
        for (int i = 0; i < 4; i++) step(0, 1, 32'h4000_0000, 0, 0, 1, 1, 0, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        compare();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule